// File: doc/BRIEF.md
# Three-Wire Control Register Receiver

This block is the device end of a three-wire control link made of a serial clock, a serial data line and an active-low framing line. While the framing line is low, each rising edge of the serial clock shifts one data bit into a 32-bit shift register. The first bit sent becomes the most significant bit. The shift register is not cleared between bursts, so a burst of any length leaves the last 32 bits received in place. When the framing line returns high after a burst that contained at least one clock edge, the shift contents are committed to a held control word. A framing low period with no clock edges at all does not commit anything; instead it flips the block between its power-down and power-up states.

All three serial inputs are brought into the system clock domain through synchronizer chains of equal depth, and edges are detected there. The system clock must run at least four times faster than the serial clock. A four-state machine sequences the frame. ST_IDLE waits for the framing line to fall. ST_SHIFT takes serial clock edges while the frame is open. When the frame closes, ST_SHIFT moves to one of two one-cycle states. It goes to ST_LOAD if the activity flag is set, and that state commits the word and powers up. It goes to ST_TOGGLE if the flag is clear, and that state flips the power state. Both one-cycle states return to ST_IDLE, or to ST_SHIFT if the frame is already low again.

The held word is decoded continuously into these outputs: the channel number and synthesized frequency, the reference select and its frequency in MHz, the output power code, the PLL-hold flag, the receive select, the DC extraction mode and the transmit ramp-up mode.

Top module: `tw_ctrl_rx`

## Requirements
- R1: While `frame_n` is low, each rising edge of `ser_clk` shifts `ser_dat` in at bit 0 and moves the earlier bits up by one. After 32 edges, the first bit sent sits at bit 31.
- R2: Edges of `ser_clk` while `frame_n` is high leave the shift contents unchanged. A later short burst shows no trace of them.
- R3: A burst longer than 32 bits commits only its last 32 bits. The bit count is never checked, and a short burst leaves older bits shifted up.
- R4: A rising edge of `frame_n` after a burst with at least one clock edge commits the shift contents to the control word. It also sets `pwr_up` to 1 and raises `load_pulse` for exactly one cycle.
- R5: A `frame_n` low period with no `ser_clk` rising edge flips `pwr_up` on its rising edge. It leaves the control word unchanged and does not raise `load_pulse`.
- R6: Field decode of the control word: bit 19 gives `ramp_mode`, bit 18 gives `dcx_mode`, bits 14:13 give `ref_sel`, bits 12:10 give `pwr_code`, bit 9 gives `pll_hold`, bit 8 gives `rx_sel` (1 = receive), and bits 7:0 give `chan_n`.
- R7: `freq_mhz` equals 2304 + `chan_n`.
- R8: `ref_mhz` is 12 when `ref_sel` is 00 and 13 when `ref_sel` is 01. For the other two codes it is 0.
- R9: After reset the control word is all zeros, `pwr_up` is 0 and `load_pulse` is 0.
- R10: A `ser_clk` rising edge that reaches the synchronized domain in the same cycle as the `frame_n` rising edge is ignored. It neither shifts a bit nor counts as activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial bus clock, data taken on its rising edge |
| ser_dat | input | 1 | Serial bus data, first bit is bit 31 |
| frame_n | input | 1 | Active-low framing line, commit or toggle on rise |
| chan_n | output | 8 | Divider value n |
| freq_mhz | output | 12 | Synthesized frequency, 2304 + n |
| ref_sel | output | 2 | Reference select code |
| ref_mhz | output | 5 | Reference frequency implied by ref_sel |
| pwr_code | output | 3 | Output power code |
| pll_hold | output | 1 | Keep PLL running for the whole slot |
| rx_sel | output | 1 | 1 selects receive, 0 transmit |
| dcx_mode | output | 1 | DC extraction mode select |
| ramp_mode | output | 1 | Transmit ramp-up mode select |
| pwr_up | output | 1 | 1 = powered up, 0 = powered down |
| load_pulse | output | 1 | One-cycle strobe when the control word is committed |

## Verification
Two events can land on the same synchronized cycle: a serial clock edge that shifts a bit and sets the activity flag, and the frame close that chooses between commit and toggle. The bench provokes this by raising `ser_clk` and `frame_n` on the same system clock edge, once in an otherwise empty frame and once right after an 8-bit burst. In the empty frame the coincident edge must be ignored, so the result must be a power toggle. After the burst it must also be ignored, so the committed word must contain only the 8 earlier bits. Both outcomes are judged from the decoded outputs, `pwr_up` and the count of `load_pulse` strobes.

// File: rtl/twc_pkg.sv
package twc_pkg;

    localparam int WORD_W = 32;

    // Bit positions inside the control word that the decoder depends on
    localparam int POS_RAMP  = 19;
    localparam int POS_DCX   = 18;
    localparam int POS_REF_H = 14;
    localparam int POS_REF_L = 13;
    localparam int POS_PWR_H = 12;
    localparam int POS_PWR_L = 10;
    localparam int POS_PLL   = 9;
    localparam int POS_RX    = 8;
    localparam int POS_CH_H  = 7;
    localparam int POS_CH_L  = 0;

    localparam logic [1:0] REF_CODE_12 = 2'b00;
    localparam logic [1:0] REF_CODE_13 = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_LOAD,
        ST_TOGGLE
    } twc_state_t;

endpackage

// File: rtl/twc_sync.sv
module twc_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/twc_shifter.sv
module twc_shifter #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [WORD_W-1:0] word
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[WORD_W-2:0], bit_in};
    end
endmodule

// File: rtl/twc_fsm.sv
module twc_fsm
    import twc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fr_s,
    input  logic       sclk_rise,
    output twc_state_t state,
    output logic       shift_en,
    output logic       load_go,
    output logic       toggle_go
);
    twc_state_t next_state;
    logic       active;
    logic       take_edge;

    // An edge counts only while the synchronized frame is low
    assign take_edge = sclk_rise && !fr_s &&
                       ((state == ST_IDLE) || (state == ST_SHIFT));

    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE:   if (!fr_s) next_state = ST_SHIFT;
            ST_SHIFT:  if (fr_s)  next_state = (active ? ST_LOAD : ST_TOGGLE);
            ST_LOAD:   next_state = fr_s ? ST_IDLE : ST_SHIFT;
            ST_TOGGLE: next_state = fr_s ? ST_IDLE : ST_SHIFT;
            default:   next_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= next_state;
    end

    // Sticky activity flag, consumed when the frame closes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                      active <= 1'b0;
        else if ((state == ST_LOAD) || (state == ST_TOGGLE)) active <= 1'b0;
        else if (take_edge)                              active <= 1'b1;
    end

    always_comb begin
        shift_en  = 1'b0;
        load_go   = 1'b0;
        toggle_go = 1'b0;
        unique case (state)
            ST_IDLE:   shift_en  = take_edge;
            ST_SHIFT:  shift_en  = take_edge;
            ST_LOAD:   load_go   = 1'b1;
            ST_TOGGLE: toggle_go = 1'b1;
            default:   shift_en  = 1'b0;
        endcase
    end
endmodule

// File: rtl/twc_decode.sv
module twc_decode
    import twc_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int CHAN_W    = 8,
    parameter int FREQ_W    = 12,
    parameter int CHAN_BASE = 2304
) (
    input  logic [WORD_W-1:0] word,
    output logic [CHAN_W-1:0] chan_n,
    output logic [FREQ_W-1:0] freq_mhz,
    output logic [1:0]        ref_sel,
    output logic [4:0]        ref_mhz,
    output logic [2:0]        pwr_code,
    output logic              pll_hold,
    output logic              rx_sel,
    output logic              dcx_mode,
    output logic              ramp_mode
);
    always_comb begin
        chan_n    = word[POS_CH_H:POS_CH_L];
        freq_mhz  = FREQ_W'(CHAN_BASE) + FREQ_W'(word[POS_CH_H:POS_CH_L]);
        ref_sel   = word[POS_REF_H:POS_REF_L];
        pwr_code  = word[POS_PWR_H:POS_PWR_L];
        pll_hold  = word[POS_PLL];
        rx_sel    = word[POS_RX];
        dcx_mode  = word[POS_DCX];
        ramp_mode = word[POS_RAMP];
        unique case (word[POS_REF_H:POS_REF_L])
            REF_CODE_12: ref_mhz = 5'd12;
            REF_CODE_13: ref_mhz = 5'd13;
            default:     ref_mhz = 5'd0;
        endcase
    end
endmodule

// File: rtl/tw_ctrl_rx.sv
module tw_ctrl_rx
    import twc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CHAN_W      = 8,
    parameter int FREQ_W      = 12,
    parameter int CHAN_BASE   = 2304
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              frame_n,
    output logic [CHAN_W-1:0] chan_n,
    output logic [FREQ_W-1:0] freq_mhz,
    output logic [1:0]        ref_sel,
    output logic [4:0]        ref_mhz,
    output logic [2:0]        pwr_code,
    output logic              pll_hold,
    output logic              rx_sel,
    output logic              dcx_mode,
    output logic              ramp_mode,
    output logic              pwr_up,
    output logic              load_pulse
);
    logic              sclk_s, dat_s, fr_s, sclk_q, sclk_rise;
    logic              shift_en, load_go, toggle_go;
    logic [WORD_W-1:0] shreg, ctrl_word;
    twc_state_t        state;

    twc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .d(ser_clk), .q(sclk_s));
    twc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .d(ser_dat), .q(dat_s));
    twc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_frm (
        .clk(clk), .rst_n(rst_n), .d(frame_n), .q(fr_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end
    assign sclk_rise = sclk_s && !sclk_q;

    twc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .fr_s(fr_s), .sclk_rise(sclk_rise),
        .state(state), .shift_en(shift_en), .load_go(load_go),
        .toggle_go(toggle_go));

    twc_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .bit_in(dat_s),
        .word(shreg));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_word <= '0;
            pwr_up    <= 1'b0;
        end else if (load_go) begin
            ctrl_word <= shreg;
            pwr_up    <= 1'b1;
        end else if (toggle_go) begin
            pwr_up    <= !pwr_up;
        end
    end

    assign load_pulse = load_go;

    twc_decode #(.WORD_W(WORD_W), .CHAN_W(CHAN_W), .FREQ_W(FREQ_W),
                 .CHAN_BASE(CHAN_BASE)) u_dec (
        .word(ctrl_word), .chan_n(chan_n), .freq_mhz(freq_mhz),
        .ref_sel(ref_sel), .ref_mhz(ref_mhz), .pwr_code(pwr_code),
        .pll_hold(pll_hold), .rx_sel(rx_sel), .dcx_mode(dcx_mode),
        .ramp_mode(ramp_mode));
endmodule

// File: rtl/twc_checker.sv
module twc_checker #(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fr_s,
    input logic              dat_s,
    input logic              shift_en,
    input logic [WORD_W-1:0] shreg,
    input logic [WORD_W-1:0] ctrl_word,
    input logic              load_pulse,
    input logic              toggle_go,
    input logic              pwr_up
);
    a_r1_shift_in_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (shreg[0] == $past(dat_s)) &&
                     (shreg[WORD_W-1:1] == $past(shreg[WORD_W-2:0])))
        else $error("R1 shift order violated");

    a_r2_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
        fr_s |=> $stable(shreg))
        else $error("R2 shift register moved while frame high");

    a_r4_load_powers_up: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> pwr_up)
        else $error("R4 commit did not power up");

    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> !load_pulse)
        else $error("R4 load strobe longer than one cycle");

    a_r5_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load_pulse |=> $stable(ctrl_word))
        else $error("R5 control word changed without commit");

    a_r5_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
        toggle_go |=> (pwr_up != $past(pwr_up)))
        else $error("R5 toggle did not flip power");

    a_r5_power_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_pulse || toggle_go) |=> $stable(pwr_up))
        else $error("R5 power changed outside frame close");
endmodule

bind tw_ctrl_rx twc_checker #(.WORD_W(twc_pkg::WORD_W)) u_twc_chk (
    .clk(clk), .rst_n(rst_n), .fr_s(fr_s), .dat_s(dat_s),
    .shift_en(shift_en), .shreg(shreg), .ctrl_word(ctrl_word),
    .load_pulse(load_pulse), .toggle_go(toggle_go), .pwr_up(pwr_up));

// File: tb/test_tw_ctrl_rx.sv
module test_tw_ctrl_rx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, frame_n = 1'b1;
    logic [7:0]  chan_n;
    logic [11:0] freq_mhz;
    logic [1:0]  ref_sel;
    logic [4:0]  ref_mhz;
    logic [2:0]  pwr_code;
    logic pll_hold, rx_sel, dcx_mode, ramp_mode, pwr_up, load_pulse;

    int checks = 0, errors = 0, loads_seen = 0, loads_exp = 0;
    logic [31:0] m_shift = '0, m_word = '0;
    logic        m_pwr = 1'b0;

    always #4 clk = ~clk;

    tw_ctrl_rx i_tw_ctrl_rx (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .frame_n(frame_n), .chan_n(chan_n), .freq_mhz(freq_mhz),
        .ref_sel(ref_sel), .ref_mhz(ref_mhz), .pwr_code(pwr_code),
        .pll_hold(pll_hold), .rx_sel(rx_sel), .dcx_mode(dcx_mode),
        .ramp_mode(ramp_mode), .pwr_up(pwr_up), .load_pulse(load_pulse));

    always @(negedge clk) if (load_pulse) loads_seen++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        int ef;
        int er;
        ef = 2304 + int'(m_word[7:0]);
        er = (m_word[14:13] == 2'b00) ? 12 : (m_word[14:13] == 2'b01) ? 13 : 0;
        chk(chan_n == m_word[7:0], {req, " R6 chan"}, chan_n, m_word[7:0]);
        chk(int'(freq_mhz) == ef, {req, " R7 freq"}, freq_mhz, ef);
        chk(ref_sel == m_word[14:13], {req, " R6 ref_sel"}, ref_sel, m_word[14:13]);
        chk(int'(ref_mhz) == er, {req, " R8 ref_mhz"}, ref_mhz, er);
        chk(pwr_code == m_word[12:10], {req, " R6 pwr"}, pwr_code, m_word[12:10]);
        chk(pll_hold == m_word[9], {req, " R6 pll"}, pll_hold, m_word[9]);
        chk(rx_sel == m_word[8], {req, " R6 rx"}, rx_sel, m_word[8]);
        chk(dcx_mode == m_word[18], {req, " R6 dcx"}, dcx_mode, m_word[18]);
        chk(ramp_mode == m_word[19], {req, " R6 ramp"}, ramp_mode, m_word[19]);
        chk(pwr_up == m_pwr, {req, " power"}, pwr_up, m_pwr);
        chk(loads_seen == loads_exp, {req, " R4 strobes"}, loads_seen, loads_exp);
    endtask

    task automatic open_frame();
        @(negedge clk) frame_n = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic close_frame();
        @(negedge clk) frame_n = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        @(negedge clk) begin ser_dat = b; ser_clk = 1'b0; end
        repeat (4) @(negedge clk);
        ser_clk = 1'b1;
        m_shift = {m_shift[30:0], b};
        repeat (3) @(negedge clk);
    endtask

    task automatic send_word(input logic [63:0] v, input int cnt);
        open_frame();
        for (int i = cnt - 1; i >= 0; i--) bit_out(v[i]);
        @(negedge clk) ser_clk = 1'b0;
        repeat (3) @(negedge clk);
        close_frame();
        m_word = m_shift; m_pwr = 1'b1; loads_exp++;
    endtask

    task automatic bare_pulse();
        open_frame();
        close_frame();
        m_pwr = !m_pwr;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check_all("R9 reset");

        bare_pulse();
        check_all("R5 bare pulse up");
        bare_pulse();
        check_all("R5 bare pulse down");

        // Sweep all divider values with other fields derived from n
        for (int n = 0; n < 256; n++) begin
            logic [31:0] w;
            w = '0;
            w[7:0]   = 8'(n);
            w[8]     = n[7];
            w[9]     = n[5];
            w[12:10] = 3'(n >> 4);
            w[14:13] = 2'(n >> 2);
            w[18]    = n[1];
            w[19]    = n[0];
            w[31:20] = 12'(n * 37);
            send_word({32'h0, w}, 32);
            check_all("R1 R4 sweep");
        end

        bare_pulse();
        check_all("R5 pulse after load");

        // Long burst: only the last 32 bits survive
        send_word(64'hA5C3_0F1E_0007_E2C9, 40);
        check_all("R3 long burst");
        send_word(64'h0000_0000_0000_0055, 8);
        check_all("R3 short burst");

        // Edges while frame high must not shift
        for (int k = 0; k < 5; k++) begin
            @(negedge clk) begin ser_dat = 1'b1; ser_clk = 1'b1; end
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
            repeat (4) @(negedge clk);
        end
        check_all("R2 idle edges outputs");
        send_word(64'h0000_0000_0000_0036, 8);
        check_all("R2 no stray bits");

        // Coincident edge in empty frame: still a toggle
        open_frame();
        @(negedge clk) begin ser_clk = 1'b1; frame_n = 1'b1; end
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
        repeat (8) @(negedge clk);
        m_pwr = !m_pwr;
        check_all("R10 empty frame");

        // Coincident final edge after 8 bits: that edge is ignored
        open_frame();
        for (int i = 7; i >= 0; i--) bit_out(1'(8'h9B >> i));
        @(negedge clk) begin ser_clk = 1'b0; ser_dat = 1'b1; end
        repeat (4) @(negedge clk);
        ser_clk = 1'b1; frame_n = 1'b1;
        repeat (4) @(negedge clk);
        ser_clk = 1'b0;
        repeat (8) @(negedge clk);
        m_word = m_shift; m_pwr = 1'b1; loads_exp++;
        check_all("R10 burst end");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule